// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block sequences one DMA channel through a programmed transfer. A one-cycle start pulse captures a source address, a destination address, a transfer count, the source and destination width codes, a burst-size code and one addressing mode for each side. In the following cycle the captured setup is validated. An illegal setup ends the job with an error pulse, and no beat is ever shown. A legal setup starts the run phase, in which the block presents one beat per cycle together with its source and destination addresses.

The bus side accepts a beat by raising a ready input while the beat is valid. Each accepted beat moves both addresses, decrements the remaining count and advances a burst counter. A burst-end flag marks the beat that closes a burst, and also the final beat of the job. An abort input ends the run at the current beat boundary. Once the job stops, the address outputs hold the ending addresses and the count output holds what is left, which is zero after a normal finish. The data path, the request lines and descriptor chaining live in other blocks.

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle. busy_o, beat_valid_o, burst_end_o, done_o, error_o and aborted_o are all 0, and count_o is 0.
- R2: Width codes 0 to 5 select 1, 2, 4, 8, 16 and 32 bytes. A source or destination width code of 6 or 7 is an error.
- R3: The burst-size code n (0 to 10) selects 2^n beats per burst. Codes 11 to 15 are an error.
- R4: The mode code is 0 for increment, 1 for decrement and 2 for fixed. A mode code of 3 on either side is an error.
- R5: A transfer count of zero is an error, and the job ends without any beat.
- R6: The source address must be a multiple of the source width, and the destination address a multiple of the destination width. Otherwise the setup is an error.
- R7: Both count × source bytes and 2^burst × source bytes must be multiples of the destination width. Otherwise the setup is an error.
- R8: beat_valid_o is high from the second cycle after start until the job ends. Each beat moves a byte count equal to the source width. On each accepted beat, each address goes up by that byte count in increment mode, goes down by it in decrement mode (wrapping modulo 2^AW), and stays put in fixed mode.
- R9: Each accepted beat lowers count_o by one. Acceptance of the final beat is followed by a one-cycle done_o pulse. At that point count_o is 0 and the address outputs hold the ending addresses.
- R10: burst_end_o is high on a valid beat that is the 2^n-th beat of its burst, or on the last beat of the job.
- R11: abort_i high during the run stops the job after that cycle. A beat accepted in that same cycle still counts. The next cycle shows aborted_o for one cycle. If that cycle accepted the final beat, done_o is shown instead. abort_i has no effect outside the run phase.
- R12: start_i is ignored while busy_o is high, so the running job continues unchanged.
- R13: Each start from idle yields exactly one of done_o, error_o or aborted_o. For an illegal setup, error_o is high two cycles after start, busy_o is low at that point, and no beat has been shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the setup and begin a job (idle only) |
| src_addr_i | input | AW | Source start address |
| dst_addr_i | input | AW | Destination start address |
| count_i | input | CW | Number of source beats |
| src_width_i | input | 3 | Source width code |
| dst_width_i | input | 3 | Destination width code |
| burst_code_i | input | 4 | Burst-size code |
| src_mode_i | input | 2 | Source addressing mode |
| dst_mode_i | input | 2 | Destination addressing mode |
| abort_i | input | 1 | Stop at the current beat boundary |
| beat_ready_i | input | 1 | Bus accepts the presented beat |
| beat_valid_o | output | 1 | A beat is presented |
| cur_src_o | output | AW | Source address of the beat, or ending address when stopped |
| cur_dst_o | output | AW | Destination address of the beat, or ending address when stopped |
| burst_end_o | output | 1 | Presented beat closes a burst |
| count_o | output | CW | Remaining beats |
| busy_o | output | 1 | Job in check or run phase |
| done_o | output | 1 | One-cycle normal completion |
| error_o | output | 1 | One-cycle setup rejection |
| aborted_o | output | 1 | One-cycle abort completion |

## Verification
Two cases are hard to reach from the ports. The first is an abort that lands in the same cycle as acceptance of the final beat, where done has to win over aborted. The second is a burst boundary that falls exactly on the largest burst code. Directed runs cover both: one holds ready high and raises abort on the last beat, and one runs just over 1024 beats with code 10. Random legal setups use random ready gaps and occasional stray start pulses, so that address stepping in all three modes is checked under stalls. They are mixed with directed setups that each break exactly one legality rule.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_RUN} seq_state_e;

  localparam logic [1:0] AM_INC = 2'd0;
  localparam logic [1:0] AM_DEC = 2'd1;
  localparam logic [1:0] AM_FIX = 2'd2;

  localparam logic [2:0] MAX_WIDTH_CODE = 3'd5;

  // Bytes carried by one beat of the given width code (legal codes only).
  function automatic logic [5:0] width_bytes(logic [2:0] code);
    return 6'(6'd1 << code);
  endfunction

  // True when any of the lowest n bits of v is set.
  function automatic logic low_bits_set(logic [63:0] v, logic [3:0] n);
    logic [63:0] mask;
    mask = (64'd1 << n) - 64'd1;
    return |(v & mask);
  endfunction

  // Next address after one accepted beat.
  function automatic logic [63:0] next_addr(logic [63:0] a, logic [1:0] mode,
                                            logic [5:0] bytes);
    case (mode)
      AM_INC:  return a + 64'(bytes);
      AM_DEC:  return a - 64'(bytes);
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/xfer_cfg_check.sv
module xfer_cfg_check
  import xfer_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MAX_BURST_CODE = 10
) (
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [2:0]    src_width_i,
  input  logic [2:0]    dst_width_i,
  input  logic [3:0]    burst_code_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  output logic          bad_o
);

  logic bad_width, bad_burst, bad_mode, bad_zero, bad_align, bad_total, bad_bburst;
  logic [4:0] burst_shift;

  assign burst_shift = 5'(burst_code_i) + 5'(src_width_i);

  always_comb begin
    bad_width  = (src_width_i > MAX_WIDTH_CODE) || (dst_width_i > MAX_WIDTH_CODE);
    bad_burst  = 32'(burst_code_i) > MAX_BURST_CODE;
    bad_mode   = (src_mode_i == 2'd3) || (dst_mode_i == 2'd3);
    bad_zero   = (count_i == '0);
    bad_align  = low_bits_set(64'(src_addr_i), {1'b0, src_width_i}) ||
                 low_bits_set(64'(dst_addr_i), {1'b0, dst_width_i});
    bad_total  = low_bits_set(64'(count_i) << src_width_i, {1'b0, dst_width_i});
    bad_bburst = burst_shift < 5'(dst_width_i);
    bad_o = bad_width | bad_burst | bad_mode | bad_zero | bad_align | bad_total | bad_bburst;
  end

endmodule

// File: rtl/xfer_addr_step.sv
module xfer_addr_step
  import xfer_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          adv_i,
  input  logic [1:0]    mode_i,
  input  logic [5:0]    bytes_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (adv_i)  addr_q <= AW'(next_addr(64'(addr_q), mode_i, bytes_i));
  end

  assign addr_o = addr_q;

  AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && mode_i == AM_FIX) |=> $stable(addr_o)); // R8

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MAX_BURST_CODE = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [2:0]    src_width_i,
  input  logic [2:0]    dst_width_i,
  input  logic [3:0]    burst_code_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic          abort_i,
  input  logic          beat_ready_i,
  output logic          beat_valid_o,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_dst_o,
  output logic          burst_end_o,
  output logic [CW-1:0] count_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o,
  output logic          aborted_o
);

  localparam int BCW = MAX_BURST_CODE + 1;

  seq_state_e    state_q;
  logic [CW-1:0] count_q;
  logic [BCW-1:0] bcnt_q;
  logic [2:0]    sw_q, dw_q;
  logic [3:0]    bc_q;
  logic [1:0]    sm_q, dm_q;
  logic          done_q, err_q, abt_q;

  // named internal events
  logic load_ev, accept_ev, final_beat, burst_last, cfg_bad, finish_ev, abort_ev;
  logic [5:0] step_bytes;
  logic [BCW-1:0] burst_len;

  assign load_ev    = (state_q == ST_IDLE) && start_i;
  assign accept_ev  = (state_q == ST_RUN) && beat_ready_i;
  assign final_beat = (count_q == CW'(1));
  assign burst_len  = BCW'(1) << bc_q;
  assign burst_last = (bcnt_q == burst_len - BCW'(1));
  assign finish_ev  = accept_ev && final_beat;
  assign abort_ev   = (state_q == ST_RUN) && abort_i && !finish_ev;
  assign step_bytes = width_bytes(sw_q);

  xfer_cfg_check #(.AW(AW), .CW(CW), .MAX_BURST_CODE(MAX_BURST_CODE)) i_check (
    .src_addr_i   (cur_src_o),
    .dst_addr_i   (cur_dst_o),
    .count_i      (count_q),
    .src_width_i  (sw_q),
    .dst_width_i  (dw_q),
    .burst_code_i (bc_q),
    .src_mode_i   (sm_q),
    .dst_mode_i   (dm_q),
    .bad_o        (cfg_bad)
  );

  logic [AW-1:0] side_load [2];
  logic [1:0]    side_mode [2];
  logic [AW-1:0] side_addr [2];

  assign side_load[0] = src_addr_i;
  assign side_load[1] = dst_addr_i;
  assign side_mode[0] = sm_q;
  assign side_mode[1] = dm_q;

  for (genvar g = 0; g < 2; g++) begin : g_side
    xfer_addr_step #(.AW(AW)) i_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_ev),
      .load_addr_i (side_load[g]),
      .adv_i       (accept_ev),
      .mode_i      (side_mode[g]),
      .bytes_i     (step_bytes),
      .addr_o      (side_addr[g])
    );
  end

  assign cur_src_o = side_addr[0];
  assign cur_dst_o = side_addr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      bcnt_q  <= '0;
      sw_q    <= '0;
      dw_q    <= '0;
      bc_q    <= '0;
      sm_q    <= '0;
      dm_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      abt_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CHECK;
          count_q <= count_i;
          bcnt_q  <= '0;
          sw_q    <= src_width_i;
          dw_q    <= dst_width_i;
          bc_q    <= burst_code_i;
          sm_q    <= src_mode_i;
          dm_q    <= dst_mode_i;
        end
        ST_CHECK: begin
          if (cfg_bad) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (accept_ev) begin
            count_q <= count_q - CW'(1);
            bcnt_q  <= burst_last ? '0 : bcnt_q + BCW'(1);
          end
          if (finish_ev) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (abort_ev) begin
            state_q <= ST_IDLE;
            abt_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign beat_valid_o = (state_q == ST_RUN);
  assign burst_end_o  = beat_valid_o && (burst_last || final_beat);
  assign count_o      = count_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign error_o      = err_q;
  assign aborted_o    = abt_q;

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !beat_valid_o)); // R13
  AST_BAD_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && cfg_bad) |=> (error_o && !busy_o)); // R13
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, error_o, aborted_o})); // R13
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (count_o == $past(count_o) - CW'(1))); // R9
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (count_o == '0 && !busy_o)); // R9
  AST_SRC_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && sm_q == AM_INC) |=> (cur_src_o == $past(cur_src_o) + AW'($past(step_bytes)))); // R8
  AST_DST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && dm_q == AM_DEC) |=> (cur_dst_o == $past(cur_dst_o) - AW'($past(step_bytes)))); // R8
  AST_LAST_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && count_o == CW'(1)) |-> burst_end_o); // R10
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && abort_i && !(beat_ready_i && count_o == CW'(1))) |=> (aborted_o && !busy_o)); // R11
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && start_i && !beat_ready_i) |=> $stable(count_o)); // R12

endmodule

// File: tb/test_xfer_seq.sv
`timescale 1ns/1ps
module test_xfer_seq;

  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [2:0]    src_width_i = '0, dst_width_i = '0;
  logic [3:0]    burst_code_i = '0;
  logic [1:0]    src_mode_i = '0, dst_mode_i = '0;
  logic          abort_i = 1'b0, beat_ready_i = 1'b0;
  logic          beat_valid_o, burst_end_o, busy_o, done_o, error_o, aborted_o;
  logic [AW-1:0] cur_src_o, cur_dst_o;
  logic [CW-1:0] count_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  xfer_seq #(.AW(AW), .CW(CW)) i_xfer_seq (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Legality computed with plain arithmetic.
  function automatic bit cfg_illegal(longint sa, longint da, longint cnt, int sw, int dw,
                                     int bc, int sm, int dm);
    longint sb, db;
    if (sw > 5 || dw > 5 || bc > 10 || sm == 3 || dm == 3 || cnt == 0) return 1;
    sb = longint'(2) ** sw;
    db = longint'(2) ** dw;
    if (sa % sb != 0 || da % db != 0) return 1;
    if ((cnt * sb) % db != 0) return 1;
    if (((longint'(2) ** bc) * sb) % db != 0) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_step(logic [31:0] a, int mode, int sw);
    logic [31:0] b;
    b = 32'(2 ** sw);
    if (mode == 0) return a + b;
    if (mode == 1) return a - b;
    return a;
  endfunction

  task automatic run_xfer(input logic [31:0] sa, input logic [31:0] da, input int cnt,
                          input int sw, input int dw, input int bc, input int sm,
                          input int dm, input int abort_at, input bit full_rdy,
                          input bit poke, input string tag);
    logic [31:0] m_src, m_dst;
    int m_cnt, k, cyc;
    bit rdy, ab, fin, bad;
    bad = cfg_illegal(longint'(sa), longint'(da), longint'(cnt), sw, dw, bc, sm, dm);
    src_addr_i = sa; dst_addr_i = da; count_i = CW'(cnt);
    src_width_i = 3'(sw); dst_width_i = 3'(dw); burst_code_i = 4'(bc);
    src_mode_i = 2'(sm); dst_mode_i = 2'(dm);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !beat_valid_o, "R13 check phase", {beat_valid_o, busy_o}, 2'b01);
    @(negedge clk);
    if (bad) begin
      chk(error_o && !busy_o && !beat_valid_o && !done_o, {tag, " reject"},
          {error_o, busy_o, beat_valid_o}, 3'b100);
      return;
    end
    chk(!error_o && beat_valid_o, {tag, " R8 accepted setup"}, {error_o, beat_valid_o}, 2'b01);
    m_src = sa; m_dst = da; m_cnt = cnt; k = 0; cyc = 0;
    while (cyc < 5000) begin
      chk(beat_valid_o, "R8 valid", beat_valid_o, 1);
      chk(cur_src_o == m_src, "R8 src addr", cur_src_o, m_src);
      chk(cur_dst_o == m_dst, "R8 dst addr", cur_dst_o, m_dst);
      chk(count_o == CW'(m_cnt), "R9 count", count_o, m_cnt);
      chk(burst_end_o == ((k + 1 == 2 ** bc) || m_cnt == 1), "R10 burst end",
          burst_end_o, (k + 1 == 2 ** bc) || m_cnt == 1);
      rdy = full_rdy ? 1'b1 : (($urandom % 4) != 0);
      ab  = (cyc == abort_at);
      beat_ready_i = rdy;
      abort_i = ab;
      if (poke && cyc == 2) begin
        start_i = 1'b1; count_i = 16'h7; src_addr_i = 32'h1234_5670; src_mode_i = 2'd0;
      end
      @(negedge clk);
      beat_ready_i = 1'b0; abort_i = 1'b0; start_i = 1'b0;
      fin = 0;
      if (rdy) begin
        fin = (m_cnt == 1);
        m_src = model_step(m_src, sm, sw);
        m_dst = model_step(m_dst, dm, sw);
        m_cnt--;
        k = (k + 1 == 2 ** bc) ? 0 : k + 1;
      end
      if (fin) begin
        chk(done_o && !aborted_o && !busy_o, "R9 done pulse", {done_o, aborted_o, busy_o}, 3'b100);
        chk(count_o == 0, "R9 count zero at end", count_o, 0);
        chk(cur_src_o == m_src && cur_dst_o == m_dst, "R9 end addresses", cur_src_o, m_src);
        @(negedge clk);
        chk(!done_o, "R13 single done", done_o, 0);
        return;
      end
      if (ab) begin
        chk(aborted_o && !done_o && !busy_o, "R11 aborted", {aborted_o, done_o, busy_o}, 3'b100);
        chk(count_o == CW'(m_cnt), "R11 remaining count", count_o, m_cnt);
        chk(cur_src_o == m_src, "R11 src held", cur_src_o, m_src);
        return;
      end
      chk(!done_o && !aborted_o && !error_o, "R13 no early outcome",
          {done_o, aborted_o, error_o}, 0);
      cyc++;
    end
    chk(0, "R9 run never ended", cyc, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(!busy_o && !beat_valid_o && !burst_end_o && count_o == 0 &&
        !done_o && !error_o && !aborted_o, "R1 reset state", {busy_o, beat_valid_o, count_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && count_o == 0, "R1 idle after release", busy_o, 0);

    // abort outside the run phase has no effect
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    chk(!aborted_o && !busy_o, "R11 abort when idle ignored", aborted_o, 0);

    // directed illegal setups
    run_xfer(32'h100, 32'h200, 4, 6, 0, 0, 0, 0, -1, 0, 0, "R2 src width 6");
    run_xfer(32'h100, 32'h200, 4, 0, 7, 0, 0, 0, -1, 0, 0, "R2 dst width 7");
    run_xfer(32'h100, 32'h200, 4, 2, 2, 11, 0, 0, -1, 0, 0, "R3 burst 11");
    run_xfer(32'h100, 32'h200, 4, 2, 2, 15, 0, 0, -1, 0, 0, "R3 burst 15");
    run_xfer(32'h100, 32'h200, 4, 2, 2, 0, 3, 0, -1, 0, 0, "R4 src mode 3");
    run_xfer(32'h100, 32'h200, 4, 2, 2, 0, 0, 3, -1, 0, 0, "R4 dst mode 3");
    run_xfer(32'h100, 32'h200, 0, 2, 2, 0, 0, 0, -1, 0, 0, "R5 zero count");
    run_xfer(32'h102, 32'h200, 4, 2, 2, 0, 0, 0, -1, 0, 0, "R6 src misaligned");
    run_xfer(32'h100, 32'h204, 4, 2, 3, 0, 0, 0, -1, 0, 0, "R6 dst misaligned");
    run_xfer(32'h100, 32'h200, 3, 0, 1, 0, 0, 0, -1, 0, 0, "R7 total bytes");
    run_xfer(32'h100, 32'h200, 4, 0, 2, 1, 0, 0, -1, 0, 0, "R7 burst bytes");

    // directed legal setups
    run_xfer(32'h100, 32'h200, 8, 0, 2, 2, 0, 0, -1, 0, 0, "R7 legal narrow source");
    run_xfer(32'h8, 32'h4, 5, 2, 2, 1, 1, 1, -1, 0, 0, "R8 decrement wrap");
    run_xfer(32'h40, 32'h80, 6, 5, 5, 1, 2, 0, -1, 0, 0, "R8 fixed source");
    run_xfer(32'h0, 32'h1000, 1030, 0, 0, 10, 0, 2, -1, 1, 0, "R10 max burst");
    run_xfer(32'h10, 32'h20, 9, 1, 1, 2, 0, 0, 3, 0, 0, "R11 mid abort");
    run_xfer(32'h10, 32'h20, 4, 1, 1, 2, 0, 0, 3, 1, 0, "R11 abort on final beat");
    run_xfer(32'h10, 32'h20, 12, 2, 1, 2, 0, 1, -1, 0, 1, "R12 start while busy");

    // constrained random legal setups
    for (int i = 0; i < 40; i++) begin
      int sw, dw, bc, sm, dm, cnt, ab;
      logic [31:0] sa, da;
      sw  = $urandom % 4;
      dw  = $urandom % (sw + 1);
      bc  = $urandom % 5;
      sm  = $urandom % 3;
      dm  = $urandom % 3;
      cnt = 1 + ($urandom % 40);
      sa  = $urandom & ~32'(2 ** sw - 1);
      da  = $urandom & ~32'(2 ** dw - 1);
      ab  = (($urandom % 5) == 0) ? int'($urandom % 30) : -1;
      run_xfer(sa, da, cnt, sw, dw, bc, sm, dm, ab, 0, (i % 7) == 0, "R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule